// File: doc/BRIEF.md
# Multi-Channel Timer PWM Bank

This block holds a bank of independent 16-bit timer channels. Each channel drives one pulse-width-modulated output pin. A channel has an up-counter, a duty compare value, a period compare value and a three-bit control word. The counter runs from zero up to the period value and then wraps. The pin holds a programmable idle level while the count is below the duty value, and the opposite level from the duty value through the period value. When the duty value is larger than the period, the pin stays at its idle level. Software starts and stops counters only through two shared bit-mask registers, one to set run bits and one to clear them. It can also write the count of any channel directly.

Turning a pin off can happen in one of two ways. An abrupt shutdown forces the pin to the idle level on the next clock. A graceful shutdown lets the current period finish first. All registers sit on a simple single-cycle write strobe with a combinational read-back.

The address map has `ADDR_W = clog2(NCH) + 3` bits, and the top address bit picks between the channel space and the global space. In the channel space, the next `clog2(NCH)` bits pick the channel and bits [1:0] pick the register: 0 control, 1 duty, 2 period, 3 count. In the global space, bits [1:0] pick the register: 0 run status (read), 1 run set, 2 run clear. The control word uses bit 0 for output enable, bit 1 for idle level high and bit 2 for abrupt shutdown.

Top module: `tmr_pwm_bank`

## Requirements
- R1: After reset all run bits, counts, duty values, period values and control words are zero and every pin is low.
- R2: A write to the run-set register (global select 1) sets run bit n for each 1 in bit n of the data. Zero bits leave their run bit unchanged. The run status register (global select 0) reads back the run bits.
- R3: A write to the run-clear register (global select 2) clears run bit n for each 1 in bit n of the data. Zero bits leave their run bit unchanged.
- R4: A running counter increases by exactly one per clock. A stopped counter holds its value.
- R5: A running counter whose value equals the period value becomes zero on the next clock.
- R6: A write to the count register (channel select 3) loads the counter on that clock, overriding any increment.
- R7: While output is enabled and duty ≤ period, each period lasts period+1 clocks. The pin is at the idle level for `duty` clocks and at the opposite level for period−duty+1 clocks, one clock after the count that selects it. A duty of zero gives the opposite level for the whole period.
- R8: When duty > period the pin stays at the idle level on every clock.
- R9: With output enable clear and the counter stopped, the pin shows the idle level on the next clock.
- R10: With output enable clear and abrupt shutdown set, the pin shows the idle level on the next clock.
- R11: With output enable cleared and abrupt shutdown clear, the pin keeps its waveform until the count has wrapped to zero. It then stays at the idle level.
- R12: New duty and period values change the waveform without the counter being restarted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one write per clock |
| bus_addr | input | ADDR_W | Register address, used for both writes and reads |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| pwm_out | output | NCH | One PWM pin per channel |

## Verification
The bound checker verifies the per-cycle rules on every clock and for every channel. These are the one-step increment, the hold while stopped, the wrap at the period value, the effect of the set and clear masks, and the idle level when duty exceeds the period or the output is shut off. Other properties span many cycles and can only be seen in the bench scenarios. These are the high and low times over whole periods for several duty and period pairs, the inverted idle level, retuning a running channel, and the exact clock on which a graceful shutdown ends. Those scenarios count high samples and rising edges over windows that are whole multiples of the period.

// File: rtl/tmr_pwm_pkg.sv
// Package: shared widths, control word layout and register selects for the
// timer PWM bank. Assumes a 16-bit data path for all timer registers.
package tmr_pwm_pkg;

    localparam int DW = 16;

    typedef logic [DW-1:0] word_t;

    // Control word: bit 0 output enable, bit 1 idle level high, bit 2 abrupt shutdown
    typedef struct packed {
        logic abrupt;
        logic idle_hi;
        logic out_en;
    } ctrl_t;

    // Register select inside one channel's window
    typedef enum logic [1:0] {
        CH_CTRL   = 2'd0,
        CH_DUTY   = 2'd1,
        CH_PERIOD = 2'd2,
        CH_COUNT  = 2'd3
    } ch_sel_e;

    // Register select inside the global window
    typedef enum logic [1:0] {
        GL_STATUS = 2'd0,
        GL_SET    = 2'd1,
        GL_CLEAR  = 2'd2,
        GL_NONE   = 2'd3
    } gl_sel_e;

endpackage

// File: rtl/tmr_pwm_counter.sv
// Module: one channel's 16-bit up-counter.
// The counter loads on a direct write, otherwise it steps by one per clock
// while running and wraps to zero after reaching the period value.
// A stopped counter holds its value. A count above the period keeps rising
// and rolls over at the top of the range.
module tmr_pwm_counter
    import tmr_pwm_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  run,
    input  logic  load,
    input  word_t load_val,
    input  word_t period,
    output word_t count
);

    // Count register: load has priority, then wrap or increment while running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (run) begin
            if (count == period) begin
                count <= '0;
            end else begin
                count <= count + word_t'(1);
            end
        end
    end

endmodule

// File: rtl/tmr_pwm_wave.sv
// Module: output stage of one channel.
// The pin is registered, so it shows the phase of the count seen one clock
// earlier. The active phase is counts from duty up to period, and it is
// never active when duty exceeds period. A gate flag holds the output on.
// Clearing the enable closes the gate at once in abrupt mode. In graceful
// mode it closes once the count is back at zero, or right away if the
// counter is stopped.
module tmr_pwm_wave
    import tmr_pwm_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  run,
    input  word_t count,
    input  word_t duty,
    input  word_t period,
    input  ctrl_t ctrl,
    output logic  pin
);

    logic gate_q;
    logic gate_nx;
    logic active;

    // Active phase of the current count
    always_comb active = (duty <= period) && (count >= duty);

    // Gate stays open while enabled, or in graceful mode until the period ends
    always_comb gate_nx = ctrl.out_en |
                          (gate_q & ~ctrl.abrupt & run & (count != '0));

    // Pin register: idle level unless the gate is open and the phase is active
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
            pin    <= 1'b0;
        end else begin
            gate_q <= gate_nx;
            pin    <= ctrl.idle_hi ^ (gate_nx & active);
        end
    end

endmodule

// File: rtl/tmr_pwm_bank.sv
// Module: top of the timer PWM bank.
// It decodes the register bus, holds the per-channel control, duty and
// period registers and the shared run bits, and builds one counter and one
// output stage per channel. Assumes NCH between 1 and 16 and at most one
// bus write per clock. Reads are combinational from bus_addr.
module tmr_pwm_bank
    import tmr_pwm_pkg::*;
#(
    parameter  int NCH    = 8,
    localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int ADDR_W = CH_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic [NCH-1:0]    pwm_out
);

    logic              glob;
    logic [CH_W-1:0]   ch_idx;
    logic [1:0]        sel;
    logic [NCH-1:0]    run_q;
    logic [NCH-1:0]    set_hit;
    logic [NCH-1:0]    clr_hit;
    logic [NCH-1:0]    cnt_wr;
    logic [NCH-1:0]    oe_v;
    logic [NCH-1:0]    init_v;
    logic [NCH-1:0]    abr_v;
    word_t [NCH-1:0]   cnt_vec;
    word_t [NCH-1:0]   duty_vec;
    word_t [NCH-1:0]   per_vec;
    ctrl_t [NCH-1:0]   ctrl_vec;

    // Address split into window, channel and register select
    always_comb begin
        glob   = bus_addr[ADDR_W-1];
        ch_idx = bus_addr[ADDR_W-2:2];
        sel    = bus_addr[1:0];
    end

    // Set and clear masks from global writes
    always_comb begin
        set_hit = '0;
        clr_hit = '0;
        if (bus_wr && glob && gl_sel_e'(sel) == GL_SET)   set_hit = bus_wdata[NCH-1:0];
        if (bus_wr && glob && gl_sel_e'(sel) == GL_CLEAR) clr_hit = bus_wdata[NCH-1:0];
    end

    // Shared run bits: set mask first, then clear mask
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else begin
            run_q <= (run_q | set_hit) & ~clr_hit;
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic hit;

        // Write strobe for this channel's window
        always_comb hit = bus_wr && !glob && (ch_idx == CH_W'(i));

        always_comb cnt_wr[i] = hit && (ch_sel_e'(sel) == CH_COUNT);

        // Channel configuration registers
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctrl_vec[i] <= '0;
                duty_vec[i] <= '0;
                per_vec[i]  <= '0;
            end else if (hit) begin
                case (ch_sel_e'(sel))
                    CH_CTRL:   ctrl_vec[i] <= ctrl_t'(bus_wdata[2:0]);
                    CH_DUTY:   duty_vec[i] <= bus_wdata;
                    CH_PERIOD: per_vec[i]  <= bus_wdata;
                    default:   ;
                endcase
            end
        end

        // Flat control bits for the bound checker
        always_comb begin
            oe_v[i]   = ctrl_vec[i].out_en;
            init_v[i] = ctrl_vec[i].idle_hi;
            abr_v[i]  = ctrl_vec[i].abrupt;
        end

        tmr_pwm_counter u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (run_q[i]),
            .load     (cnt_wr[i]),
            .load_val (bus_wdata),
            .period   (per_vec[i]),
            .count    (cnt_vec[i])
        );

        tmr_pwm_wave u_wave (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (run_q[i]),
            .count  (cnt_vec[i]),
            .duty   (duty_vec[i]),
            .period (per_vec[i]),
            .ctrl   (ctrl_vec[i]),
            .pin    (pwm_out[i])
        );
    end

    // Combinational read-back of the addressed register
    always_comb begin
        bus_rdata = '0;
        if (glob) begin
            if (gl_sel_e'(sel) == GL_STATUS) bus_rdata[NCH-1:0] = run_q;
        end else if (int'(ch_idx) < NCH) begin
            case (ch_sel_e'(sel))
                CH_CTRL:   bus_rdata[2:0] = ctrl_vec[ch_idx];
                CH_DUTY:   bus_rdata = duty_vec[ch_idx];
                CH_PERIOD: bus_rdata = per_vec[ch_idx];
                default:   bus_rdata = cnt_vec[ch_idx];
            endcase
        end
    end

endmodule

// File: rtl/tmr_pwm_bank_chk.sv
// Checker: per-cycle rules of the timer PWM bank, checked on every channel.
// Attached to every tmr_pwm_bank instance by the bind at the end of the file.
module tmr_pwm_bank_chk
    import tmr_pwm_pkg::*;
#(
    parameter int NCH = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NCH-1:0]  run_q,
    input logic [NCH-1:0]  set_hit,
    input logic [NCH-1:0]  clr_hit,
    input logic [NCH-1:0]  cnt_wr,
    input logic [NCH-1:0]  oe_v,
    input logic [NCH-1:0]  init_v,
    input logic [NCH-1:0]  abr_v,
    input word_t [NCH-1:0] cnt_vec,
    input word_t [NCH-1:0] duty_vec,
    input word_t [NCH-1:0] per_vec,
    input logic [NCH-1:0]  pwm_out
);

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        AST_SET_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
            set_hit[i] |=> run_q[i]); // R2

        AST_CLR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
            clr_hit[i] |=> !run_q[i]); // R3

        AST_MASK_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
            (!set_hit[i] && !clr_hit[i]) |=> run_q[i] == $past(run_q[i])); // R2

        AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
            (run_q[i] && !cnt_wr[i] && cnt_vec[i] != per_vec[i])
            |=> cnt_vec[i] == word_t'($past(cnt_vec[i]) + word_t'(1))); // R4

        AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
            (!run_q[i] && !cnt_wr[i]) |=> $stable(cnt_vec[i])); // R4

        AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (run_q[i] && !cnt_wr[i] && cnt_vec[i] == per_vec[i])
            |=> cnt_vec[i] == '0); // R5

        AST_DUTY_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
            (duty_vec[i] > per_vec[i]) |=> pwm_out[i] == $past(init_v[i])); // R8

        AST_OFF_STOPPED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            (!oe_v[i] && !run_q[i]) |=> pwm_out[i] == $past(init_v[i])); // R9

        AST_ABRUPT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            (!oe_v[i] && abr_v[i]) |=> pwm_out[i] == $past(init_v[i])); // R10
    end

endmodule

bind tmr_pwm_bank tmr_pwm_bank_chk #(.NCH(NCH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_q    (run_q),
    .set_hit  (set_hit),
    .clr_hit  (clr_hit),
    .cnt_wr   (cnt_wr),
    .oe_v     (oe_v),
    .init_v   (init_v),
    .abr_v    (abr_v),
    .cnt_vec  (cnt_vec),
    .duty_vec (duty_vec),
    .per_vec  (per_vec),
    .pwm_out  (pwm_out)
);

// File: tb/sim_tmr_pwm_bank.sv
`timescale 1ns/1ps
// Bench: scoreboard for the timer PWM bank. The driver configures channels
// and queues expected waveform figures. The monitor measures high samples
// and rising edges over a whole number of periods and compares them.
// Direct register and shutdown checks are made inline.
module sim_tmr_pwm_bank;

    localparam int NCH    = 8;
    localparam int ADDR_W = $clog2(NCH) + 3;
    localparam int GBASE  = 1 << (ADDR_W - 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [15:0]       bus_wdata = '0;
    logic [15:0]       bus_rdata;
    logic [NCH-1:0]    pwm_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    bit mon_busy = 1'b0;

    string q_req[$];
    int    q_ch[$];
    int    q_win[$];
    int    q_hi[$];
    int    q_edg[$];

    tmr_pwm_bank #(.NCH(NCH)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    always #2 clk = ~clk;

    // One comparison with its report line
    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Bus write, called at a negedge; returns at the next negedge
    task automatic wr(input int addr, input int data);
        bus_wr    = 1'b1;
        bus_addr  = ADDR_W'(addr);
        bus_wdata = 16'(data);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Combinational read
    task automatic rd(input int addr, output int data);
        bus_addr = ADDR_W'(addr);
        #1;
        data = int'(bus_rdata);
    endtask

    function automatic int ca(input int ch, input int s);
        return ch * 4 + s;
    endfunction

    // Restart a channel from count zero with a new setup
    task automatic cfg(input int ch, input int per, input int duty, input int ctrl);
        wr(GBASE + 2, 1 << ch);
        wr(ca(ch, 3), 0);
        wr(ca(ch, 1), duty);
        wr(ca(ch, 2), per);
        wr(ca(ch, 0), ctrl);
        wr(GBASE + 1, 1 << ch);
    endtask

    // Queue the expected figures for four periods and wait for the monitor
    task automatic expect_wave(input string req, input int ch, input int per,
                               input int duty, input bit init_hi);
        int k = 4;
        int hi;
        int edg;
        repeat (per + 4) @(negedge clk);
        if (duty <= per) begin
            hi  = init_hi ? k * duty : k * (per - duty + 1);
            edg = (duty == 0) ? 0 : k;
        end else begin
            hi  = init_hi ? k * (per + 1) : 0;
            edg = 0;
        end
        q_req.push_back(req);
        q_ch.push_back(ch);
        q_win.push_back(k * (per + 1));
        q_hi.push_back(hi);
        q_edg.push_back(edg);
        wait (q_req.size() == 0);
        wait (!mon_busy);
        @(negedge clk);
    endtask

    // Monitor: measure high samples and rising edges, compare with the queue
    initial begin
        forever begin
            string req;
            int ch, win, ehi, eedg, hi, edg;
            bit prev, v;
            wait (q_req.size() > 0);
            mon_busy = 1'b1;
            req  = q_req.pop_front();
            ch   = q_ch.pop_front();
            win  = q_win.pop_front();
            ehi  = q_hi.pop_front();
            eedg = q_edg.pop_front();
            hi = 0;
            edg = 0;
            prev = pwm_out[ch];
            for (int n = 0; n < win; n++) begin
                @(negedge clk);
                v = pwm_out[ch];
                if (v) hi++;
                if (v && !prev) edg++;
                prev = v;
            end
            chk({req, " high samples"}, hi, ehi);
            chk({req, " rising edges"}, edg, eedg);
            mon_busy = 1'b0;
        end
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Driver
    initial begin
        int d;
        int run_hi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 pins", int'(pwm_out), 0);
        rd(GBASE + 0, d); chk("R1 run status", d, 0);
        rd(ca(3, 3), d);  chk("R1 count", d, 0);
        rd(ca(3, 2), d);  chk("R1 period", d, 0);
        @(negedge clk);

        // R2: set mask, zero bits ignored
        wr(GBASE + 1, 16'h0004); rd(GBASE + 0, d); chk("R2 set bit 2", d, 4);
        @(negedge clk);
        wr(GBASE + 1, 16'h0000); rd(GBASE + 0, d); chk("R2 zero mask keeps", d, 4);
        @(negedge clk);
        wr(GBASE + 1, 16'h0001); rd(GBASE + 0, d); chk("R2 set bit 0", d, 5);
        @(negedge clk);
        // R3: clear mask, zero bits ignored
        wr(GBASE + 2, 16'h0004); rd(GBASE + 0, d); chk("R3 clear bit 2", d, 1);
        @(negedge clk);
        wr(GBASE + 2, 16'h0000); rd(GBASE + 0, d); chk("R3 zero mask keeps", d, 1);
        @(negedge clk);
        wr(GBASE + 2, 16'h0001); rd(GBASE + 0, d); chk("R3 clear bit 0", d, 0);
        @(negedge clk);

        // R6: direct load; R4: step of one per clock, hold when stopped
        wr(ca(2, 2), 16'hFFFF);
        wr(ca(2, 3), 5);
        rd(ca(2, 3), d); chk("R6 count load", d, 5);
        @(negedge clk);
        wr(GBASE + 1, 1 << 2);
        repeat (9) @(negedge clk);
        wr(GBASE + 2, 1 << 2);
        rd(ca(2, 3), d); chk("R4 ten steps", d, 15);
        repeat (6) @(negedge clk);
        rd(ca(2, 3), d); chk("R4 hold while stopped", d, 15);
        @(negedge clk);

        // R5: wrap at the period value
        wr(ca(2, 2), 20);
        wr(ca(2, 3), 19);
        wr(GBASE + 1, 1 << 2);
        repeat (2) @(negedge clk);
        wr(GBASE + 2, 1 << 2);
        rd(ca(2, 3), d); chk("R5 wrap through zero", d, 1);
        @(negedge clk);

        // R7 / R8: waveform shapes
        cfg(0, 9, 3, 5);   expect_wave("R7 duty 3 period 9", 0, 9, 3, 1'b0);
        cfg(0, 4, 4, 5);   expect_wave("R7 duty equals period", 0, 4, 4, 1'b0);
        cfg(0, 9, 0, 5);   expect_wave("R7 duty zero", 0, 9, 0, 1'b0);
        cfg(1, 20, 5, 7);  expect_wave("R7 idle high", 1, 20, 5, 1'b1);
        cfg(0, 9, 12, 5);  expect_wave("R8 duty above period", 0, 9, 12, 1'b0);
        cfg(1, 6, 9, 7);   expect_wave("R8 duty above period idle high", 1, 6, 9, 1'b1);

        // R12: retune a running channel
        cfg(0, 9, 3, 5);
        repeat (5) @(negedge clk);
        wr(ca(0, 1), 7);   expect_wave("R12 new duty", 0, 9, 7, 1'b0);
        wr(ca(0, 2), 15);  expect_wave("R12 new period", 0, 15, 7, 1'b0);

        // R9: enable clear with counter stopped, idle high
        wr(GBASE + 2, 1 << 1);
        wr(ca(1, 0), 2);
        @(negedge clk);
        run_hi = 0;
        for (int n = 0; n < 30; n++) begin
            @(negedge clk);
            if (pwm_out[1]) run_hi++;
        end
        chk("R9 idle level while off", run_hi, 30);

        // R10: abrupt shutdown, idle low, pin opposite level beforehand
        cfg(3, 99, 0, 5);
        repeat (20) @(negedge clk);
        chk("R10 pin active before", int'(pwm_out[3]), 1);
        wr(ca(3, 0), 4);
        chk("R10 same clock still active", int'(pwm_out[3]), 1);
        @(negedge clk);
        chk("R10 idle on next clock", int'(pwm_out[3]), 0);

        // R11: graceful shutdown ends at the period boundary
        cfg(4, 99, 0, 1);
        repeat (20) @(negedge clk);
        wr(ca(4, 3), 0);
        wr(ca(4, 0), 0);
        run_hi = 0;
        while (pwm_out[4] && run_hi < 300) begin
            run_hi++;
            @(negedge clk);
        end
        chk("R11 period completed", run_hi, 100);
        repeat (150) @(negedge clk);
        chk("R11 stays idle", int'(pwm_out[4]), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule